// File: doc/BRIEF.md
# First-Order Fixed-Point IIR Section

This block is one recursive filter stage for a digital feedback loop. Every clock cycle it accepts a 24-bit signed sample and returns a 24-bit signed result. It computes `y[n] = (b0*x[n] + b1*x[n-1] - a1*y[n-1]) / 2^26`. All three coefficients are 35-bit signed integers that have already been multiplied by 2^26, so the value 2^26 stands for a gain of one. The normalisation is an arithmetic right shift by 26 bits and needs no divider. Several sections can be cascaded to build higher-order loop shapes.

The stage has a staging path for coefficients. The three coefficient inputs are captured together on a single load strobe, so the arithmetic never works with a partly updated set. A clear input empties the filter history without resetting the coefficients. A bypass input sends the raw input to the output through the output register only. The data path has three register stages. The first forms the feed-forward sum. The second closes the single-cycle recursion and saturates the internal state to 35 bits. The third clamps the result to 24 bits, or selects the bypass sample.

Top module: `iir1_section`

## Requirements
- R1: After a synchronous active-low reset, the output, the filter history and all active coefficients are zero. Until the first load, the output therefore stays zero for any input.
- R2: With coefficients held constant and starting from cleared history, each output equals sat24(s[n]). Here s[n] = sat35((b0*x[n] + b1*x[n-1] - a1*s[n-1]) >>> 26), using exact integer products and an arithmetic (floor) shift.
- R3: A sample applied before clock edge k appears at the output after edge k+2, which is a latency of exactly three clock edges. A new sample is accepted and a new result produced on every cycle.
- R4: The output clamps to the range -8388608 to 8388607 and never wraps.
- R5: The internal recursive state s[n] clamps to the range -2^34 to 2^34-1 and never wraps, so recovery from an overload follows the clamped value.
- R6: While bypass is high, the output after an edge equals the input sampled at that edge, which is a latency of one edge.
- R7: Changes on the coefficient inputs have no effect on the output until load is high at a clock edge. At that edge b0, b1 and a1 all become active together.
- R8: A high clear at an edge sets x[n-1], the feed-forward register and s[n-1] to zero. With zero input the output is zero from the second edge after the clear onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Empties the filter history |
| bypass_i | input | 1 | Routes the input to the output register |
| cfg_load_i | input | 1 | Captures the three coefficient inputs as the active set |
| cfg_b0_i | input | 35 | Staged b0, signed, scaled by 2^26 |
| cfg_b1_i | input | 35 | Staged b1, signed, scaled by 2^26 |
| cfg_a1_i | input | 35 | Staged a1, signed, scaled by 2^26 |
| x_i | input | 24 | Input sample, signed |
| y_o | output | 24 | Filtered or bypassed sample, signed |

## Verification
The assertions assume that reset is held low for at least one edge before any checked behaviour. They also assume that control inputs change only between edges and that a clear or load takes effect in the very next cycle with no other qualification. The clamp properties assume the bypass select is low when the internal state is compared against the 24-bit limits. The bench changes every input on the falling edge, holds reset for several cycles, and runs each filter case from a cleared history. This keeps each run aligned with the bench's own reference model, which is computed from R2 in wide integer arithmetic.

// File: rtl/iir1_pkg.sv
// Shared constants and types for the first-order IIR section.
// Assumes the data width stays below the coefficient width.
package iir1_pkg;
    localparam int IIR_DATA_W     = 24;   // external sample width
    localparam int IIR_COEF_W     = 35;   // internal data and coefficient width
    localparam int IIR_NORM_SHIFT = 26;   // log2 of the unity coefficient
    localparam int IIR_NUM_COEF   = 3;    // b0, b1, a1

    // Output register source selection.
    typedef enum logic {
        OUT_FILTER = 1'b0,
        OUT_BYPASS = 1'b1
    } out_sel_e;
endpackage

// File: rtl/iir1_coef_bank.sv
// Active coefficient bank. Stages every coefficient in parallel and
// transfers all of them on a single load strobe, so the data path never
// sees a mixed set. Index 0 = b0, 1 = b1, 2 = a1.
module iir1_coef_bank #(
    parameter int CW = 35,
    parameter int N  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [N-1:0][CW-1:0] stage_i,
    output logic [N-1:0][CW-1:0] act_o
);
    for (genvar g = 0; g < N; g++) begin : g_coef
        logic [CW-1:0] act_r;

        // Capture this coefficient on the load strobe, zero on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      act_r <= '0;
            else if (load_i) act_r <= stage_i[g];
        end

        assign act_o[g] = act_r;
    end
endmodule

// File: rtl/iir1_ff_stage.sv
// Feed-forward stage: registers b0*x[n] + b1*x[n-1] at full precision
// and keeps x[n-1]. Assumes CW > DW so that the input sign-extends.
module iir1_ff_stage #(
    parameter int DW = 24,
    parameter int CW = 35
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic signed [DW-1:0]   x_i,
    input  logic signed [CW-1:0]   b0_i,
    input  logic signed [CW-1:0]   b1_i,
    output logic signed [2*CW:0]   ff_o,
    output logic signed [CW-1:0]   x_prev_o
);
    localparam int PW  = 2 * CW;
    localparam int FFW = PW + 1;

    logic signed [CW-1:0]  x_ext;
    logic signed [PW-1:0]  prod_cur;
    logic signed [PW-1:0]  prod_prev;
    logic signed [FFW-1:0] ff_next;

    // Form both products at full width and add them.
    always_comb begin
        x_ext     = {{(CW-DW){x_i[DW-1]}}, x_i};
        prod_cur  = $signed({{CW{b0_i[CW-1]}}, b0_i}) * $signed({{CW{x_ext[CW-1]}}, x_ext});
        prod_prev = $signed({{CW{b1_i[CW-1]}}, b1_i}) * $signed({{CW{x_prev_o[CW-1]}}, x_prev_o});
        ff_next   = {prod_cur[PW-1], prod_cur} + {prod_prev[PW-1], prod_prev};
    end

    // Register the feed-forward sum and the delayed input.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ff_o     <= '0;
            x_prev_o <= '0;
        end else begin
            ff_o     <= ff_next;
            x_prev_o <= x_ext;
        end
    end
endmodule

// File: rtl/iir1_fb_stage.sv
// Recursive stage: s[n] = sat((ff - a1*s[n-1]) >>> SHIFT) to CW bits.
// The whole recursion closes in one cycle so throughput is one per clock.
module iir1_fb_stage #(
    parameter int CW    = 35,
    parameter int SHIFT = 26
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic signed [2*CW:0]   ff_i,
    input  logic signed [CW-1:0]   a1_i,
    output logic signed [CW-1:0]   state_o
);
    localparam int PW   = 2 * CW;
    localparam int SUMW = PW + 2;
    localparam logic signed [SUMW-1:0] HI = {{(SUMW-CW+1){1'b0}}, {(CW-1){1'b1}}};
    localparam logic signed [SUMW-1:0] LO = {{(SUMW-CW+1){1'b1}}, {(CW-1){1'b0}}};

    logic signed [PW-1:0]   fb_prod;
    logic signed [SUMW-1:0] acc;
    logic signed [SUMW-1:0] acc_norm;
    logic signed [CW-1:0]   state_next;

    // Subtract the feedback product, normalise, clamp to CW bits.
    always_comb begin
        fb_prod  = $signed({{CW{a1_i[CW-1]}}, a1_i}) * $signed({{CW{state_o[CW-1]}}, state_o});
        acc      = {ff_i[PW], ff_i} - {{2{fb_prod[PW-1]}}, fb_prod};
        acc_norm = acc >>> SHIFT;
        if (acc_norm > HI)      state_next = HI[CW-1:0];
        else if (acc_norm < LO) state_next = LO[CW-1:0];
        else                    state_next = acc_norm[CW-1:0];
    end

    // Hold the recursive state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) state_o <= '0;
        else                   state_o <= state_next;
    end
endmodule

// File: rtl/iir1_out_stage.sv
// Output stage: clamps the CW-bit state to DW bits, or selects the raw
// input when bypass is requested. Assumes CW > DW.
module iir1_out_stage
    import iir1_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 35
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bypass_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [CW-1:0] state_i,
    output logic signed [DW-1:0] y_o
);
    localparam logic signed [CW-1:0] HI = {{(CW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [CW-1:0] LO = {{(CW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW-1:0] clamped;
    out_sel_e             sel;

    // Clamp the state to the output range and pick the source.
    always_comb begin
        if (state_i > HI)      clamped = HI[DW-1:0];
        else if (state_i < LO) clamped = LO[DW-1:0];
        else                   clamped = state_i[DW-1:0];
        sel = bypass_i ? OUT_BYPASS : OUT_FILTER;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) y_o <= '0;
        else begin
            unique case (sel)
                OUT_BYPASS: y_o <= x_i;
                default:    y_o <= clamped;
            endcase
        end
    end
endmodule

// File: rtl/iir1_section.sv
// First-order IIR section, three register stages, one sample per clock.
// Coefficients are signed integers scaled by 2^SHIFT; they are staged on
// the cfg inputs and applied together on cfg_load_i.
module iir1_section
    import iir1_pkg::*;
#(
    parameter int DW    = IIR_DATA_W,
    parameter int CW    = IIR_COEF_W,
    parameter int SHIFT = IIR_NORM_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 bypass_i,
    input  logic                 cfg_load_i,
    input  logic signed [CW-1:0] cfg_b0_i,
    input  logic signed [CW-1:0] cfg_b1_i,
    input  logic signed [CW-1:0] cfg_a1_i,
    input  logic signed [DW-1:0] x_i,
    output logic signed [DW-1:0] y_o
);
    localparam int NC  = IIR_NUM_COEF;
    localparam int FFW = 2 * CW + 1;

    logic [NC-1:0][CW-1:0] coef_stage;
    logic [NC-1:0][CW-1:0] coef_act;
    logic signed [FFW-1:0] ff_sum;
    logic signed [CW-1:0]  x_prev;
    logic signed [CW-1:0]  y_state;

    assign coef_stage = {cfg_a1_i, cfg_b1_i, cfg_b0_i};

    iir1_coef_bank #(.CW(CW), .N(NC)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cfg_load_i),
        .stage_i (coef_stage),
        .act_o   (coef_act)
    );

    iir1_ff_stage #(.DW(DW), .CW(CW)) u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .x_i      (x_i),
        .b0_i     ($signed(coef_act[0])),
        .b1_i     ($signed(coef_act[1])),
        .ff_o     (ff_sum),
        .x_prev_o (x_prev)
    );

    iir1_fb_stage #(.CW(CW), .SHIFT(SHIFT)) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .ff_i    (ff_sum),
        .a1_i    ($signed(coef_act[2])),
        .state_o (y_state)
    );

    iir1_out_stage #(.DW(DW), .CW(CW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass_i (bypass_i),
        .x_i      (x_i),
        .state_i  (y_state),
        .y_o      (y_o)
    );
endmodule

// File: rtl/iir1_section_chk.sv
// Property checker for iir1_section, attached with bind below.
module iir1_section_chk #(
    parameter int DW = 24,
    parameter int CW = 35,
    parameter int NC = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clear_i,
    input logic                 bypass_i,
    input logic                 cfg_load_i,
    input logic signed [DW-1:0] x_i,
    input logic signed [DW-1:0] y_o,
    input logic signed [CW-1:0] x_prev,
    input logic signed [CW-1:0] y_state,
    input logic [NC-1:0][CW-1:0] coef_act
);
    localparam logic signed [CW-1:0] HI = {{(CW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [CW-1:0] LO = {{(CW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (y_o == '0 && y_state == '0 && coef_act == '0));

    assert_clamp_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && y_state > HI) |=> (y_o == HI[DW-1:0]));

    assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && y_state < LO) |=> (y_o == LO[DW-1:0]));

    assert_bypass_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> (y_o == $past(x_i)));

    assert_coef_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load_i |=> $stable(coef_act));

    assert_clear_history_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (x_prev == '0 && y_state == '0));
endmodule

bind iir1_section iir1_section_chk #(.DW(DW), .CW(CW), .NC(NC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .bypass_i   (bypass_i),
    .cfg_load_i (cfg_load_i),
    .x_i        (x_i),
    .y_o        (y_o),
    .x_prev     (x_prev),
    .y_state    (y_state),
    .coef_act   (coef_act)
);

// File: tb/tb_iir1_section.sv
// Directed bench for iir1_section: one task per scenario, each checking
// its own results against a wide-integer model of the requirements.
module tb_iir1_section;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clear_i = 1'b0;
    logic               bypass_i = 1'b0;
    logic               cfg_load_i = 1'b0;
    logic signed [34:0] cfg_b0_i = '0;
    logic signed [34:0] cfg_b1_i = '0;
    logic signed [34:0] cfg_a1_i = '0;
    logic signed [23:0] x_i = '0;
    logic signed [23:0] y_o;

    int checks = 0;
    int fails  = 0;
    int seed   = 32'h1234_5678;

    logic signed [23:0] xs [0:255];
    logic signed [23:0] ex [0:255];

    localparam logic signed [34:0] UNITY = 35'sd67108864;

    iir1_section dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .bypass_i(bypass_i),
        .cfg_load_i(cfg_load_i), .cfg_b0_i(cfg_b0_i), .cfg_b1_i(cfg_b1_i),
        .cfg_a1_i(cfg_a1_i), .x_i(x_i), .y_o(y_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic signed [23:0] act,
                       input logic signed [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic signed [23:0] rnd();
        seed = seed * 1103515245 + 12345;
        return seed[30:7];
    endfunction

    // Reference from R2, R4, R5 in 128-bit integers.
    task automatic model(input logic signed [34:0] b0, input logic signed [34:0] b1,
                         input logic signed [34:0] a1, input int n);
        logic signed [127:0] w0, w1, wa, xp, sp, xn, acc;
        w0 = b0; w1 = b1; wa = a1; xp = 0; sp = 0;
        for (int i = 0; i < n; i++) begin
            xn  = xs[i];
            acc = (w0 * xn + w1 * xp - wa * sp) >>> 26;
            if (acc > 128'sd17179869183)       acc = 128'sd17179869183;
            else if (acc < -128'sd17179869184) acc = -128'sd17179869184;
            sp = acc;
            xp = xn;
            if (acc > 128'sd8388607)       ex[i] = 24'sd8388607;
            else if (acc < -128'sd8388608) ex[i] = -24'sd8388608;
            else                           ex[i] = acc[23:0];
        end
    endtask

    task automatic load_coefs(input logic signed [34:0] b0, input logic signed [34:0] b1,
                              input logic signed [34:0] a1);
        @(negedge clk);
        cfg_b0_i = b0; cfg_b1_i = b1; cfg_a1_i = a1; cfg_load_i = 1'b1;
        @(negedge clk);
        cfg_load_i = 1'b0;
    endtask

    // Clear history, stream xs[0..n-1], compare at three-edge lag.
    task automatic run_filter(input string req, input logic signed [34:0] b0,
                              input logic signed [34:0] b1, input logic signed [34:0] a1,
                              input int n);
        model(b0, b1, a1, n);
        @(negedge clk);
        clear_i = 1'b1; x_i = '0;
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            clear_i = 1'b0;
            if (i >= 3) chk(req, y_o, ex[i-3]);
            x_i = (i < n) ? xs[i] : '0;
        end
    endtask

    task automatic t_reset();
        chk("R1", y_o, '0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 3) chk("R1", y_o, '0);
            x_i = 24'sd3000000 - 24'(i * 1000);
        end
    endtask

    task automatic t_latency();
        for (int i = 0; i < 40; i++) xs[i] = 24'(i * 7919 - 150000);
        xs[10] = 24'sd8000000;
        load_coefs(UNITY, '0, '0);
        run_filter("R3", UNITY, '0, '0, 40);
    endtask

    task automatic t_response();
        for (int i = 0; i < 40; i++) xs[i] = 24'sd1000000;
        for (int i = 40; i < 90; i++) xs[i] = rnd();
        load_coefs(35'sd4194304, 35'sd4194304, -35'sd58720256);
        run_filter("R2", 35'sd4194304, 35'sd4194304, -35'sd58720256, 90);
        for (int i = 0; i < 60; i++) xs[i] = rnd();
        load_coefs(35'sd50331648, -35'sd33554432, 35'sd33554432);
        run_filter("R2", 35'sd50331648, -35'sd33554432, 35'sd33554432, 60);
    endtask

    task automatic t_out_sat();
        for (int i = 0; i < 50; i++) xs[i] = rnd();
        xs[0] = 24'sd8388607; xs[1] = -24'sd8388608;
        load_coefs(35'sd268435456, '0, '0);
        run_filter("R4", 35'sd268435456, '0, '0, 50);
    endtask

    task automatic t_int_sat();
        for (int i = 0; i < 24; i++) xs[i] = 24'sd8388607;
        for (int i = 24; i < 90; i++) xs[i] = -24'sd8388607;
        load_coefs(35'sd8589934592, '0, -UNITY);
        run_filter("R5", 35'sd8589934592, '0, -UNITY, 90);
    endtask

    task automatic t_bypass();
        load_coefs(35'sd4194304, 35'sd4194304, -35'sd58720256);
        for (int i = 0; i < 20; i++) xs[i] = rnd();
        @(negedge clk);
        bypass_i = 1'b1;
        for (int i = 0; i < 21; i++) begin
            @(negedge clk);
            if (i > 0) chk("R6", y_o, xs[i-1]);
            x_i = (i < 20) ? xs[i] : '0;
        end
        bypass_i = 1'b0;
    endtask

    task automatic t_load();
        for (int i = 0; i < 30; i++) xs[i] = rnd() >>> 2;
        load_coefs(UNITY, '0, '0);
        @(negedge clk);
        cfg_b0_i = 35'sd134217728; cfg_b1_i = UNITY; cfg_a1_i = 35'sd16777216;
        run_filter("R7", UNITY, '0, '0, 30);
        @(negedge clk);
        cfg_load_i = 1'b1;
        @(negedge clk);
        cfg_load_i = 1'b0;
        run_filter("R7", 35'sd134217728, UNITY, 35'sd16777216, 30);
    endtask

    task automatic t_clear();
        load_coefs(UNITY, '0, -UNITY);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            x_i = 24'sd1000;
        end
        @(negedge clk);
        clear_i = 1'b1; x_i = '0;
        @(negedge clk);
        clear_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R8", y_o, '0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_response();
        t_out_sat();
        t_int_sat();
        t_bypass();
        t_load();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule